// File: doc/BRIEF.md
# Crosspoint Active-Configuration Latch and Switch Decoder

This block holds the live routing state of an eight-output by eight-input crosspoint. A separate front end assembles a 40-bit configuration word (the first rank) and presents it on `rank1_i`. While the update strobe and the chip enable are both low, this block copies that word into its own second-rank storage. It then turns each output's stored select code into a one-hot group of switch enables, and it drives a per-output enable. While the strobe is high, the first rank can be rewritten freely and the active routing does not move.

The configuration word holds one 5-bit field per output. Output `k` owns bits `[5k+4:5k]`. Bits `[5k+2:5k]` give the binary input select. Bit `5k+3` is a reserved marker that the decoder ignores. Bit `5k+4` enables the output. Switch enable `sw_en_o[8k+i]` connects input `i` to output `k`.

An asynchronous active-low reset clears only the enable state, so every output goes off at once. The outputs then stay off until the next update. Whatever the first rank holds at that update is applied exactly as it stands, including power-up garbage. The storage behaves as a clocked transparent latch: each rising clock edge with both strobes low captures the word. Holding the strobes low therefore makes the routing follow every intermediate state of the first rank.

Top module: `xpt_rank2_decode`

## Requirements
- R1: Driving `rst_n` low clears `out_en_o` and `sw_en_o` to all zeros at once, with no clock edge needed. They stay zero while `rst_n` is low, even when `upd_n` and `ce_n` are both low.
- R2: After `rst_n` returns high, every output stays disabled until the first rising clock edge with `upd_n` and `ce_n` both low. That edge applies the first-rank word present at that moment.
- R3: A rising clock edge with `upd_n` low and `ce_n` low captures all 40 bits of `rank1_i`. The new routing is visible on the outputs right after that edge.
- R4: While `upd_n` and `ce_n` stay low, the outputs follow `rank1_i` on every rising edge, one edge behind. Intermediate values are not filtered out.
- R5: On a rising edge where `upd_n` is high or `ce_n` is high, `out_en_o` and `sw_en_o` keep their values, whatever `rank1_i` does.
- R6: For each output `k`, `out_en_o[k]` equals stored bit `5k+4`. When that bit is 1, exactly one of `sw_en_o[8k+7:8k]` is set: the bit at position `8k+s`, where `s` is stored bits `[5k+2:5k]`.
- R7: When an output's stored enable bit is 0, all eight of its switch enables are 0 for every select value.
- R8: Several outputs may hold the same select value. Each of them then asserts its own switch enable for that input (multicast).
- R9: The reserved bit `5k+3` has no effect on any output.
- R10: An update applies whatever the first rank holds, even an arbitrary word never written on purpose (power-up contents). Nothing in that word is masked or replaced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the second rank samples on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; disables every output |
| ce_n | input | 1 | Active-low chip enable gating the update |
| upd_n | input | 1 | Active-low update strobe; held low makes the second rank follow the first |
| rank1_i | input | 40 | First-rank configuration word, 5 bits per output |
| sw_en_o | output | 64 | Switch enables, bit 8k+i connects input i to output k |
| out_en_o | output | 8 | Per-output enable, 1 drives the output |

## Verification
The bench attacks the places where a latch-plus-decoder is most often wrong. It checks that a disabled output with a non-zero select still drives no switch; a decoder that ignores the enable would close a crosspoint on a floating output. It asserts reset mid-cycle and releases it while the first rank changes, to catch a reset that waits for a clock or an output that wakes up without an update. It holds the update strobe low across a shifting first rank and expects every intermediate routing to appear, so a design that only acts on the strobe edge is exposed. It also raises chip enable alone with the strobe low, and flips the reserved bits, to catch a gate on the wrong signal or a decoder that reads the wrong field.

// File: rtl/xpt_rank2_decode.sv
module xpt_rank2_decode #(
  parameter int NUM_OUT = 8,
  parameter int NUM_IN  = 8
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        ce_n,
  input  logic                                        upd_n,
  input  logic [NUM_OUT*($clog2(NUM_IN)+2)-1:0]       rank1_i,
  output logic [NUM_OUT*NUM_IN-1:0]                   sw_en_o,
  output logic [NUM_OUT-1:0]                          out_en_o
);

  localparam int SEL_W  = $clog2(NUM_IN);
  localparam int FLD_W  = SEL_W + 2;
  localparam int RSV_B  = SEL_W;
  localparam int EN_B   = SEL_W + 1;

  logic load;
  logic [NUM_OUT-1:0] unused_rsv;

  assign load = ~upd_n & ~ce_n;

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    logic             en_r;
    logic [SEL_W-1:0] sel_r;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    en_r <= 1'b0;
      else if (load) en_r <= rank1_i[k*FLD_W + EN_B];
    end

    always_ff @(posedge clk) begin
      if (load) sel_r <= rank1_i[k*FLD_W +: SEL_W];
    end

    assign out_en_o[k]   = en_r;
    assign unused_rsv[k] = rank1_i[k*FLD_W + RSV_B];

    for (genvar i = 0; i < NUM_IN; i++) begin : g_in
      assign sw_en_o[k*NUM_IN + i] = en_r && (sel_r == SEL_W'(i));
    end
  end

endmodule

module xpt_rank2_decode_chk #(
  parameter int NUM_OUT = 8,
  parameter int NUM_IN  = 8
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic                                  ce_n,
  input logic                                  upd_n,
  input logic [NUM_OUT*($clog2(NUM_IN)+2)-1:0] rank1_i,
  input logic [NUM_OUT*NUM_IN-1:0]             sw_en_o,
  input logic [NUM_OUT-1:0]                    out_en_o
);
  localparam int FLD_W = $clog2(NUM_IN) + 2;
  localparam int EN_B  = $clog2(NUM_IN) + 1;

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_n || ce_n) |=> ($stable(out_en_o) && $stable(sw_en_o))); // R5

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_chk
    AST_OFF_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en_o[k] |-> (sw_en_o[k*NUM_IN +: NUM_IN] == '0)); // R7

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      out_en_o[k] |-> ($countones(sw_en_o[k*NUM_IN +: NUM_IN]) == 1)); // R6

    AST_FOLLOW_RANK1: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_n && !ce_n) |=> (out_en_o[k] == $past(rank1_i[k*FLD_W + EN_B]))); // R4
  end
endmodule

bind xpt_rank2_decode xpt_rank2_decode_chk #(.NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN)) chk_i (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .upd_n(upd_n),
  .rank1_i(rank1_i), .sw_en_o(sw_en_o), .out_en_o(out_en_o)
);

// File: tb/xpt_rank2_decode_tb.sv
module xpt_rank2_decode_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1;
  logic        upd_n = 1'b1;
  logic [39:0] rank1 = '0;
  logic [63:0] sw_en;
  logic [7:0]  out_en;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  logic [7:0] m_en = '0;
  logic [2:0] m_sel [8];

  always #5 clk = ~clk;

  xpt_rank2_decode dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .upd_n(upd_n),
    .rank1_i(rank1), .sw_en_o(sw_en), .out_en_o(out_en)
  );

  function automatic logic [39:0] mk(input logic [7:0] en, input logic [23:0] sels,
                                     input logic [7:0] rsv);
    logic [39:0] v;
    for (int k = 0; k < 8; k++) begin
      v[k*5 +: 3] = sels[k*3 +: 3];
      v[k*5 + 3]  = rsv[k];
      v[k*5 + 4]  = en[k];
    end
    return v;
  endfunction

  task automatic model_load(input logic [39:0] v);
    for (int k = 0; k < 8; k++) begin
      m_en[k]  = v[k*5 + 4];
      m_sel[k] = v[k*5 +: 3];
    end
  endtask

  function automatic logic [63:0] exp_sw();
    logic [63:0] e = '0;
    for (int k = 0; k < 8; k++) if (m_en[k]) e[k*8 + m_sel[k]] = 1'b1;
    return e;
  endfunction

  task automatic check(input string req);
    nvec++;
    if (out_en !== m_en || sw_en !== exp_sw()) begin
      nbad++;
      $display("FAIL %s: out_en=%h sw_en=%h expected out_en=%h sw_en=%h",
               req, out_en, sw_en, m_en, exp_sw());
    end
  endtask

  task automatic pulse_update(input logic [39:0] v);
    @(negedge clk);
    rank1 = v; ce_n = 1'b0; upd_n = 1'b0;
    @(negedge clk);
    upd_n = 1'b1; ce_n = 1'b1;
    model_load(v);
  endtask

  task automatic t_powerup();
    pulse_update(40'hD3_9B_62_E7_14);
    check("R10 power-up word applied unmasked");
  endtask

  task automatic t_basic();
    pulse_update(mk(8'hFF, {3'd7,3'd6,3'd5,3'd4,3'd3,3'd2,3'd1,3'd0}, 8'hFF));
    check("R3 identity routing");
    pulse_update(mk(8'hA5, {3'd0,3'd1,3'd2,3'd3,3'd4,3'd5,3'd6,3'd7}, 8'hFF));
    check("R6 reversed routing mixed enables");
  endtask

  task automatic t_disabled();
    pulse_update(mk(8'h00, 24'hFAC688, 8'hFF));
    check("R7 all disabled nonzero selects");
    pulse_update(mk(8'h5A, 24'h7E5D39, 8'h3C));
    check("R7 partial disable");
  endtask

  task automatic t_multicast();
    pulse_update(mk(8'hFF, {8{3'b101}}, 8'hFF));
    check("R8 input 5 to all outputs");
    pulse_update(mk(8'h0F, {8{3'b000}}, 8'hFF));
    check("R8 input 0 to four outputs");
  endtask

  task automatic t_reserved();
    pulse_update(mk(8'hC3, 24'h1B4E92, 8'h00));
    check("R9 reserved bits zero");
    pulse_update(mk(8'hC3, 24'h1B4E92, 8'hFF));
    check("R9 reserved bits one");
  endtask

  task automatic t_hold();
    pulse_update(mk(8'hFF, 24'h53977A, 8'hFF));
    check("R5 baseline");
    @(negedge clk); ce_n = 1'b0; upd_n = 1'b1;
    for (int j = 0; j < 3; j++) begin
      rank1 = 40'h12_3456_789A ^ (40'h1F << (j*5));
      @(negedge clk);
      check("R5 strobe high holds");
    end
    ce_n = 1'b1; upd_n = 1'b0;
    for (int j = 0; j < 3; j++) begin
      rank1 = ~rank1;
      @(negedge clk);
      check("R5 chip enable high holds");
    end
    upd_n = 1'b1;
  endtask

  task automatic t_transparent();
    logic [39:0] v = mk(8'hFF, 24'h000000, 8'hFF);
    @(negedge clk);
    ce_n = 1'b0; upd_n = 1'b0;
    for (int j = 0; j < 8; j++) begin
      v = {v[38:0], v[39] ^ v[20] ^ 1'b1};
      rank1 = v;
      @(negedge clk);
      model_load(v);
      check("R4 follows shifting first rank");
    end
    upd_n = 1'b1; ce_n = 1'b1;
    rank1 = '0;
    @(negedge clk);
    check("R4 freezes when strobe rises");
  endtask

  task automatic t_reset();
    pulse_update(mk(8'hFF, 24'hFAC688, 8'hFF));
    check("R3 before reset");
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1 m_en = '0;
    check("R1 async clear mid-cycle");
    ce_n = 1'b0; upd_n = 1'b0; rank1 = mk(8'hFF, 24'h123456, 8'hFF);
    repeat (2) @(negedge clk);
    check("R1 held clear with update low");
    upd_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
    #2 rst_n = 1'b1;
    for (int j = 0; j < 3; j++) begin
      rank1 = mk(8'hFF, 24'h654321 + 24'(j), 8'hFF);
      @(negedge clk);
      check("R2 stays disabled after release");
    end
    pulse_update(rank1);
    check("R2 next update programs first rank");
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) m_sel[k] = '0;
    repeat (3) @(negedge clk);
    check("R1 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 disabled before first update");
    t_powerup();
    t_basic();
    t_disabled();
    t_multicast();
    t_reserved();
    t_hold();
    t_transparent();
    t_reset();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule